// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns parallel audio samples into a single serial data line with a matching frame-sync output. It can frame the stream as standard two-channel I2S, as left-justified two-channel audio, or as a time-division multiplexed (TDM) frame of one to eight 32-bit slots. TDM comes in two variants: data one bit late, or data aligned to the frame-sync edge. Bit timing comes from a one-cycle bit-clock enable pulse, `bclk_en`, supplied by the surrounding clock logic. Every output change happens on a cycle in which that pulse is high.

Samples arrive through a valid/ready input. The block asks for a new word at the start of each slot that needs one. If no word is offered at that moment, it raises a one-cycle underrun flag and fills the slot. The fill is either zero or a repeat of the last accepted word, as configured.

Mono duplication lets one word serve a pair of slots. Two packed sample lengths let one 32-bit word carry two short samples. All configuration inputs are static while the block is enabled.

Top module: `aud_ser_tx`

## Requirements
- R1: While `enable` is low, `fs_o`, `sd_o`, `underrun_o` and `smp_ready` are all low. The first `bclk_en` pulse after `enable` rises starts a fresh frame at slot 0 and bit 0. No underrun fill word survives from an earlier run.
- R2: `cfg_fmt` selects the framing:
  - Code 0 (I2S): data is delayed one bit after the frame-sync edge; `fs_o` is low for the left slot and high for the right slot.
  - Code 1 (left-justified): same frame-sync polarity as code 0, with data starting on the frame-sync edge.
  - Code 2 (TDM): data is one bit late.
  - Code 3 (TDM left-justified): data is aligned with the frame-sync edge.
- R3: `cfg_dlen` sets the sample length. Codes 0 to 7 give 32, 24, 20, 18, 16, 16 (packed), 8 and 8 (packed) bits. A sample is taken from the low bits of `smp_data` and sent MSB first at the start of its slot. The remaining slot bits are zero.
- R4: In codes 0 and 1, the slot width depends on `cfg_dlen`:
  - Length code 0: 32 bits.
  - Length codes 1 to 3: 24 bits when `cfg_slot24` is 1, otherwise 32 bits.
  - Length codes 4 and 5: 16 bits.
  - Length codes 6 and 7: 8 bits.
  - In TDM every slot is 32 bits and `cfg_slot24` has no effect.
- R5: In TDM, `cfg_nch_m1` holds the channel count minus one. A frame is (`cfg_nch_m1`+1)×32 bit periods, and the slots are sent in ascending order.
- R6: In TDM, `fs_o` goes high at bit 0 of each frame. It stays high for 32 bits with `cfg_fs_width`=0, for half the frame with code 1, and for one bit with codes 2 and 3. `fs_o` changes only on a `bclk_en` cycle or when the block is disabled.
- R7: `smp_ready` is high only in a `bclk_en` cycle that begins a slot needing a new word. A word is consumed when `smp_valid` and `smp_ready` are both high in that cycle.
- R8: When `smp_ready` is high and `smp_valid` is low, `underrun_o` is high in the next cycle, and only then. The slot carries zero when `cfg_repeat` is 0, or the most recently accepted word when `cfg_repeat` is 1 (zero if none was accepted since enable).
- R9: With `cfg_mono` set, a word is fetched only for even-numbered slots. Each odd slot repeats the sample sent in the slot before it.
- R10: With length codes 5 and 7, one word feeds an even slot and the odd slot after it. The even slot takes the low half (bits 15:0 or 7:0); the odd slot takes the next half (bits 31:16 or 15:8). When `cfg_mono` is also set, both slots take the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low holds the block idle |
| bclk_en | input | 1 | One-cycle pulse marking each bit period |
| cfg_fmt | input | 2 | Framing select (R2) |
| cfg_dlen | input | 3 | Sample length code (R3) |
| cfg_slot24 | input | 1 | 24-bit slot for mid-size samples (R4) |
| cfg_nch_m1 | input | 3 | TDM channel count minus one (R5) |
| cfg_fs_width | input | 2 | TDM frame-sync width code (R6) |
| cfg_mono | input | 1 | Duplicate even slot into odd slot (R9) |
| cfg_repeat | input | 1 | Underrun fill: 0 zero, 1 last word (R8) |
| smp_valid | input | 1 | Sample word offered |
| smp_data | input | 32 | Sample word |
| smp_ready | output | 1 | Word taken this cycle when valid |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle underrun flag |

## Verification
The framing is checked with both two-channel formats at 16-, 18-, 24- and 8-bit lengths, with 24- and 32-bit slots for the same length. Both TDM variants are run with three, four and eight channels, covering every frame-sync width. Comparing the one-bit-late and edge-aligned formats shows whether the data delay is applied per format. Pairing 18- or 24-bit samples with both slot widths shows whether the zero tail of a slot is sized correctly. Mono and packed runs count the words consumed and check which half of each word reaches which slot. Starving the input with both fill policies, and a mid-frame disable followed by a restart, show that fills, the flag and the frame origin follow the handshake rather than the slot count.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned CH_MAX = 8;
  localparam int unsigned CH_W   = $clog2(CH_MAX);
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned POS_W  = $clog2(CH_MAX * WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BIT_W:0]    width_t;
  typedef logic [BIT_W-1:0]  bit_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [POS_W:0]    len_t;
  typedef logic [CH_W-1:0]   ch_t;

  // framing codes
  localparam logic [1:0] FMT_STD      = 2'd0;
  localparam logic [1:0] FMT_LEFT     = 2'd1;
  localparam logic [1:0] FMT_TDM      = 2'd2;
  localparam logic [1:0] FMT_TDM_LEFT = 2'd3;

  // sample length in bits for a length code
  function automatic width_t f_data_len(input logic [2:0] code);
    case (code)
      3'd0:    return width_t'(32);
      3'd1:    return width_t'(24);
      3'd2:    return width_t'(20);
      3'd3:    return width_t'(18);
      3'd4,
      3'd5:    return width_t'(16);
      default: return width_t'(8);
    endcase
  endfunction

  // bit periods per slot
  function automatic width_t f_slot_w(input logic tdm, input logic [2:0] code,
                                      input logic slot24);
    if (tdm) return width_t'(WORD_W);
    case (code)
      3'd0:         return width_t'(WORD_W);
      3'd1, 3'd2,
      3'd3:         return slot24 ? width_t'(24) : width_t'(WORD_W);
      3'd4, 3'd5:   return width_t'(16);
      default:      return width_t'(8);
    endcase
  endfunction

  // bit periods per frame
  function automatic len_t f_frame_len(input logic tdm, input width_t sw,
                                       input ch_t nch_m1);
    if (tdm) return (len_t'(nch_m1) + len_t'(1)) * len_t'(WORD_W);
    return len_t'(sw) << 1;
  endfunction

  // index of the final slot in a frame
  function automatic ch_t f_last_slot(input logic tdm, input ch_t nch_m1);
    return tdm ? nch_m1 : ch_t'(1);
  endfunction

  // number of bit periods the TDM frame sync stays high
  function automatic len_t f_sync_len(input logic [1:0] code, input len_t flen);
    case (code)
      2'd0:    return len_t'(WORD_W);
      2'd1:    return flen >> 1;
      default: return len_t'(1);
    endcase
  endfunction

  function automatic logic f_packed(input logic [2:0] code);
    return (code == 3'd5) || (code == 3'd7);
  endfunction

  // formats whose data trails the frame sync by one bit
  function automatic logic f_late(input logic [1:0] fmt);
    return (fmt == FMT_STD) || (fmt == FMT_TDM);
  endfunction

  // pick the low or next half-field and move it to the top of the word
  function automatic word_t f_align(input word_t w, input width_t n, input logic hi);
    word_t src;
    word_t mask;
    src  = hi ? (w >> n) : w;
    mask = (n >= width_t'(WORD_W)) ? '1 : ((word_t'(1) << n) - word_t'(1));
    return (src & mask) << (width_t'(WORD_W) - n);
  endfunction

endpackage

// File: rtl/aud_tx_timing.sv
module aud_tx_timing
  import aud_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   tick,
  input  logic   is_tdm,
  input  width_t slot_w,
  input  len_t   frame_len,
  input  ch_t    last_slot,
  input  len_t   sync_len,
  output logic   step,
  output logic   slot_start,
  output ch_t    slot_nxt,
  output logic   fs_o
);

  logic run_q;
  bit_t bcnt_q, bcnt_n;
  ch_t  sidx_q;
  pos_t fpos_q, fpos_n;
  logic fs_q, fs_n;
  logic start, slot_end, frame_end;

  always_comb begin
    step      = enable && tick;
    start     = step && !run_q;
    slot_end  = (bcnt_q == bit_t'(slot_w - width_t'(1)));
    frame_end = (fpos_q == pos_t'(frame_len - len_t'(1)));

    if (start || slot_end) bcnt_n = '0;
    else                   bcnt_n = bcnt_q + bit_t'(1);

    if (start)         slot_nxt = '0;
    else if (slot_end) slot_nxt = (sidx_q == last_slot) ? '0 : sidx_q + ch_t'(1);
    else               slot_nxt = sidx_q;

    if (start || frame_end) fpos_n = '0;
    else                    fpos_n = fpos_q + pos_t'(1);

    fs_n       = is_tdm ? (len_t'(fpos_n) < sync_len) : (slot_nxt != '0);
    slot_start = step && (bcnt_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bcnt_q <= '0;
      sidx_q <= '0;
      fpos_q <= '0;
      fs_q   <= 1'b0;
    end else if (!enable) begin
      run_q  <= 1'b0;
      bcnt_q <= '0;
      sidx_q <= '0;
      fpos_q <= '0;
      fs_q   <= 1'b0;
    end else if (step) begin
      run_q  <= 1'b1;
      bcnt_q <= bcnt_n;
      sidx_q <= slot_nxt;
      fpos_q <= fpos_n;
      fs_q   <= fs_n;
    end
  end

  assign fs_o = fs_q;

endmodule

// File: rtl/aud_tx_feed.sv
module aud_tx_feed
  import aud_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  slot_start,
  input  logic  slot_odd,
  input  logic  paired,
  input  logic  split,
  input  logic  repeat_last,
  input  logic  smp_valid,
  input  word_t smp_data,
  output logic  smp_ready,
  output word_t raw_word,
  output logic  raw_hi,
  output logic  underrun_o
);

  word_t last_acc_q;
  word_t pair_q;
  logic  und_q;
  logic  need;
  word_t fill;

  always_comb begin
    need      = !paired || !slot_odd;
    smp_ready = slot_start && need;
    fill      = repeat_last ? last_acc_q : '0;
    if (need) raw_word = smp_valid ? smp_data : fill;
    else      raw_word = pair_q;
    raw_hi    = !need && split;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_acc_q <= '0;
      pair_q     <= '0;
      und_q      <= 1'b0;
    end else if (!enable) begin
      last_acc_q <= '0;
      pair_q     <= '0;
      und_q      <= 1'b0;
    end else begin
      und_q <= smp_ready && !smp_valid;
      if (smp_ready) pair_q <= raw_word;
      if (smp_ready && smp_valid) last_acc_q <= smp_data;
    end
  end

  assign underrun_o = und_q;

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift
  import aud_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  step,
  input  logic  load,
  input  word_t load_val,
  input  logic  late,
  output logic  sd_o
);

  word_t sreg_q;
  logic  dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dly_q  <= 1'b0;
    end else if (!enable) begin
      sreg_q <= '0;
      dly_q  <= 1'b0;
    end else if (step) begin
      dly_q  <= sreg_q[WORD_W-1];
      sreg_q <= load ? load_val : (sreg_q << 1);
    end
  end

  assign sd_o = late ? dly_q : sreg_q[WORD_W-1];

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bclk_en,
  input  logic [1:0]        cfg_fmt,
  input  logic [2:0]        cfg_dlen,
  input  logic              cfg_slot24,
  input  logic [CH_W-1:0]   cfg_nch_m1,
  input  logic [1:0]        cfg_fs_width,
  input  logic              cfg_mono,
  input  logic              cfg_repeat,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  output logic              smp_ready,
  output logic              fs_o,
  output logic              sd_o,
  output logic              underrun_o
);

  // derived configuration
  logic   is_tdm, late, paired, split;
  width_t data_len, slot_w;
  len_t   frame_len, sync_len;
  ch_t    last_slot;

  assign is_tdm    = cfg_fmt[1];
  assign late      = f_late(cfg_fmt);
  assign data_len  = f_data_len(cfg_dlen);
  assign slot_w    = f_slot_w(is_tdm, cfg_dlen, cfg_slot24);
  assign frame_len = f_frame_len(is_tdm, slot_w, cfg_nch_m1);
  assign last_slot = f_last_slot(is_tdm, cfg_nch_m1);
  assign sync_len  = f_sync_len(cfg_fs_width, frame_len);
  assign paired    = cfg_mono || f_packed(cfg_dlen);
  assign split     = f_packed(cfg_dlen) && !cfg_mono;

  // internal events, named for the checker
  logic  ev_step;
  logic  ev_slot_start;
  ch_t   ev_slot_idx;
  word_t raw_word;
  logic  raw_hi;
  word_t load_val;

  aud_tx_timing u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (bclk_en),
    .is_tdm     (is_tdm),
    .slot_w     (slot_w),
    .frame_len  (frame_len),
    .last_slot  (last_slot),
    .sync_len   (sync_len),
    .step       (ev_step),
    .slot_start (ev_slot_start),
    .slot_nxt   (ev_slot_idx),
    .fs_o       (fs_o)
  );

  aud_tx_feed u_feed (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .slot_start  (ev_slot_start),
    .slot_odd    (ev_slot_idx[0]),
    .paired      (paired),
    .split       (split),
    .repeat_last (cfg_repeat),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .smp_ready   (smp_ready),
    .raw_word    (raw_word),
    .raw_hi      (raw_hi),
    .underrun_o  (underrun_o)
  );

  assign load_val = f_align(raw_word, data_len, raw_hi);

  aud_tx_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .step     (ev_step),
    .load     (ev_slot_start),
    .load_val (load_val),
    .late     (late),
    .sd_o     (sd_o)
  );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       bclk_en,
  input logic [1:0] cfg_fmt,
  input logic [2:0] cfg_dlen,
  input logic [1:0] cfg_fs_width,
  input logic       cfg_mono,
  input logic       smp_valid,
  input logic       smp_ready,
  input logic       fs_o,
  input logic       sd_o,
  input logic       underrun_o,
  input logic       slot_start,
  input logic       slot_odd
);

  // R7: a word is requested only on a bit tick that opens a slot
  p_ready_on_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> (bclk_en && enable && slot_start));

  // R1: disabled block drives quiet outputs
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fs_o && !sd_o && !underrun_o));

  // R8: missing word raises the flag next cycle
  p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid) |=> underrun_o);

  // R8: the flag has no other cause
  p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> $past(smp_ready && !smp_valid));

  // R9 and R10: paired modes fetch only for even slots
  p_pair_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && (cfg_mono || cfg_dlen == 3'd5 || cfg_dlen == 3'd7)) |-> !slot_odd);

  // R6: frame sync moves only on a bit tick or on disable
  p_fs_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_o) |-> $past(bclk_en || !enable));

  // R6: single-bit TDM frame sync lasts one bit period
  p_fs_bit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bclk_en && fs_o && cfg_fmt >= 2'd2 && cfg_fs_width >= 2'd2) |=> !fs_o);

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .bclk_en      (bclk_en),
  .cfg_fmt      (cfg_fmt),
  .cfg_dlen     (cfg_dlen),
  .cfg_fs_width (cfg_fs_width),
  .cfg_mono     (cfg_mono),
  .smp_valid    (smp_valid),
  .smp_ready    (smp_ready),
  .fs_o         (fs_o),
  .sd_o         (sd_o),
  .underrun_o   (underrun_o),
  .slot_start   (ev_slot_start),
  .slot_odd     (ev_slot_idx[0])
);

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/100ps
module sim_aud_ser_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        bclk_en = 1'b0;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [2:0]  cfg_dlen = 3'd0;
  logic        cfg_slot24 = 1'b0;
  logic [2:0]  cfg_nch_m1 = 3'd0;
  logic [1:0]  cfg_fs_width = 2'd0;
  logic        cfg_mono = 1'b0;
  logic        cfg_repeat = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        smp_ready, fs_o, sd_o, underrun_o;

  always #2.5 clk = ~clk;

  aud_ser_tx u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_en(bclk_en),
    .cfg_fmt(cfg_fmt), .cfg_dlen(cfg_dlen), .cfg_slot24(cfg_slot24),
    .cfg_nch_m1(cfg_nch_m1), .cfg_fs_width(cfg_fs_width), .cfg_mono(cfg_mono),
    .cfg_repeat(cfg_repeat), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .fs_o(fs_o), .sd_o(sd_o), .underrun_o(underrun_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mem [64];
  int lens [8] = '{32, 24, 20, 18, 16, 16, 8, 8};
  bit cap_fs [512];
  bit cap_sd [512];
  int idx, und_cnt, nvalid;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---- reference model from the requirements ----
  function automatic int m_slot();
    if (cfg_fmt >= 2) return 32;
    case (cfg_dlen)
      3'd0: return 32;
      3'd1, 3'd2, 3'd3: return cfg_slot24 ? 24 : 32;
      3'd4, 3'd5: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic int m_nslots();
    return (cfg_fmt >= 2) ? int'(cfg_nch_m1) + 1 : 2;
  endfunction

  function automatic bit m_paired();
    return cfg_mono || cfg_dlen == 3'd5 || cfg_dlen == 3'd7;
  endfunction

  function automatic bit m_bit(input int k);
    int sw, len, ns, flen, p, f, s, b, w;
    bit half;
    logic [31:0] word, fld;
    if (k < 0) return 1'b0;
    sw = m_slot(); len = lens[cfg_dlen]; ns = m_nslots(); flen = ns * sw;
    p = k % flen; f = k / flen; s = p / sw; b = p % sw;
    if (m_paired()) begin
      w = f * ((ns + 1) / 2) + s / 2;
      half = !cfg_mono && (s % 2 == 1);
    end else begin
      w = f * ns + s;
      half = 1'b0;
    end
    if (w < nvalid) word = mem[w];
    else if (cfg_repeat && nvalid > 0) word = mem[nvalid - 1];
    else word = '0;
    fld = half ? (word >> len) : word;
    if (b >= len) return 1'b0;
    return fld[len - 1 - b];
  endfunction

  function automatic bit m_sd(input int k);
    if (cfg_fmt == 2'd0 || cfg_fmt == 2'd2) return m_bit(k - 1);
    return m_bit(k);
  endfunction

  function automatic bit m_fs(input int k);
    int sw, flen, p, sl;
    sw = m_slot(); flen = m_nslots() * sw; p = k % flen;
    if (cfg_fmt < 2) return (p / sw) == 1;
    case (cfg_fs_width)
      2'd0: sl = 32;
      2'd1: sl = flen / 2;
      default: sl = 1;
    endcase
    return p < sl;
  endfunction

  function automatic int m_fetches(input int n);
    int sw, c;
    sw = m_slot(); c = 0;
    for (int k = 0; k < n; k++)
      if (k % sw == 0 && (!m_paired() || ((k % (m_nslots() * sw)) / sw) % 2 == 0)) c++;
    return c;
  endfunction

  // ---- stimulus ----
  task automatic setup(input logic [1:0] fmt, input logic [2:0] dl, input bit s24,
                       input logic [2:0] nch, input logic [1:0] fsw, input bit mono,
                       input bit rep, input int nv);
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    cfg_fmt = fmt; cfg_dlen = dl; cfg_slot24 = s24; cfg_nch_m1 = nch;
    cfg_fs_width = fsw; cfg_mono = mono; cfg_repeat = rep;
    nvalid = nv; idx = 0; und_cnt = 0;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic run_bits(input int n);
    bit hs;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bclk_en = 1'b1;
      smp_valid = (idx < nvalid);
      smp_data = (idx < 64) ? mem[idx] : '0;
      #1 hs = smp_ready && smp_valid;
      @(negedge clk);
      bclk_en = 1'b0;
      if (hs) idx++;
      cap_fs[k] = fs_o;
      cap_sd[k] = sd_o;
      if (underrun_o) und_cnt++;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic verify(input string tag, input int n);
    int bad_sd, bad_fs, k_sd, k_fs, f;
    bad_sd = 0; bad_fs = 0; k_sd = 0; k_fs = 0;
    for (int k = n - 1; k >= 0; k--) begin
      if (cap_sd[k] != m_sd(k)) begin bad_sd++; k_sd = k; end
      if (cap_fs[k] != m_fs(k)) begin bad_fs++; k_fs = k; end
    end
    chk(bad_sd == 0, tag, $sformatf("sd at bit %0d", k_sd), cap_sd[k_sd], m_sd(k_sd));
    chk(bad_fs == 0, tag, $sformatf("fs at bit %0d", k_fs), cap_fs[k_fs], m_fs(k_fs));
    f = m_fetches(n);
    chk(idx == ((f < nvalid) ? f : nvalid), tag, "words consumed", idx,
        (f < nvalid) ? f : nvalid);
    chk(und_cnt == ((f > nvalid) ? f - nvalid : 0), tag, "underrun pulses", und_cnt,
        (f > nvalid) ? f - nvalid : 0);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk(!fs_o && !sd_o && !underrun_o && !smp_ready, "R1", "outputs in reset",
        {fs_o, sd_o, underrun_o, smp_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); bclk_en = 1'b1; #1;
    chk(!smp_ready, "R1", "ready while disabled", smp_ready, 0);
    @(negedge clk); bclk_en = 1'b0;
    chk(!fs_o && !sd_o, "R1", "outputs while disabled", {fs_o, sd_o}, 0);
  endtask

  task automatic t_i2s16();     // R2 R3 R4: one-bit-late, 16-bit slots
    setup(2'd0, 3'd4, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(96); verify("R2", 96);
  endtask

  task automatic t_lj24();      // R3 R4: 24-bit data in 24- then 32-bit slots
    setup(2'd1, 3'd1, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(144); verify("R4", 144);
    setup(2'd1, 3'd1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(128); verify("R4", 128);
  endtask

  task automatic t_short_lens(); // R3: 18-bit in 32-bit slot, 8-bit slots
    setup(2'd0, 3'd3, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(128); verify("R3", 128);
    setup(2'd1, 3'd6, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(48); verify("R3", 48);
  endtask

  task automatic t_tdm();        // R5 R6: three sync widths, slot24 ignored in TDM
    setup(2'd2, 3'd0, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 64); run_bits(256); verify("R5", 256);
    setup(2'd3, 3'd4, 1'b0, 3'd2, 2'd1, 1'b0, 1'b0, 64); run_bits(192); verify("R6", 192);
    setup(2'd2, 3'd2, 1'b1, 3'd7, 2'd2, 1'b0, 1'b0, 64); run_bits(288); verify("R6", 288);
  endtask

  task automatic t_mono();       // R9
    setup(2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b1, 1'b0, 64); run_bits(128); verify("R9", 128);
    setup(2'd3, 3'd1, 1'b0, 3'd4, 2'd0, 1'b1, 1'b0, 64); run_bits(160); verify("R9", 160);
  endtask

  task automatic t_packed();     // R10
    setup(2'd1, 3'd5, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(96); verify("R10", 96);
    setup(2'd2, 3'd7, 1'b0, 3'd3, 2'd2, 1'b0, 1'b0, 64); run_bits(128); verify("R10", 128);
    setup(2'd1, 3'd7, 1'b0, 3'd0, 2'd0, 1'b1, 1'b0, 64); run_bits(32); verify("R10", 32);
  endtask

  task automatic t_underrun();   // R7 R8
    setup(2'd1, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1); run_bits(128); verify("R8", 128);
    setup(2'd0, 3'd4, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 2); run_bits(96); verify("R8", 96);
    setup(2'd3, 3'd5, 1'b0, 3'd2, 2'd0, 1'b0, 1'b1, 1); run_bits(192); verify("R7", 192);
  endtask

  task automatic t_restart();    // R1: mid-frame stop, then fresh frame
    setup(2'd1, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64); run_bits(40);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!fs_o && !sd_o && !underrun_o, "R1", "outputs after stop",
        {fs_o, sd_o, underrun_o}, 0);
    setup(2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 1); run_bits(96); verify("R1", 96);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 7);
    repeat (3) @(negedge clk);
    t_reset();
    t_i2s16();
    t_lj24();
    t_short_lens();
    t_tdm();
    t_mono();
    t_packed();
    t_underrun();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule